// File: doc/BRIEF.md
# Processor Status Register with Privilege Check

This block holds the processor's 16-bit status word. The word has three parts: four condition bits taken from ALU results, a 4-bit processor-state field, and a 4-bit address-state field. The condition bits are reloaded from the ALU result and carry after every logical, shift or arithmetic operation. In every other cycle they hold their value. Software or microcode can also overwrite the whole word through a load port, and this load takes precedence over an ALU update in the same cycle.

The address-state field goes straight out to the memory paging logic, which uses it to choose a page register set. The processor-state field goes out to the memory-protect logic as its access key. Privileged instructions may run only when the processor-state field is zero. When a privileged instruction is signalled while the field is non-zero, the block raises a violation flag in that same cycle. A condition-test port takes a mask over the four condition bits and reports whether any selected bit is set, so that the sequencer can make conditional decisions.

Top module: `psr_core`

## Requirements
- R1: After reset (rst_ni low) the whole status word reads 0, which is the privileged state, and the violation flag is low.
- R2: The status word layout is: bit 15 = C, bit 14 = P, bit 13 = Z, bit 12 = N, bits 11:8 reserved and always reading 0, bits 7:4 = processor state, bits 3:0 = address state.
- R3: Operation-class encoding: alu_op_i 0 = none, 1 = logical, 2 = shift, 3 = arithmetic. On any non-zero class without a load, C takes alu_carry_i on the next clock edge.
- R4: On an ALU update, exactly one of P, Z and N is set. Z is set when the result is zero. N is set when the result's top bit is 1. P is set when the result is non-zero with top bit 0.
- R5: With alu_op_i = 0 and no load, the status word is unchanged.
- R6: A load (load_en_i high) writes load_data_i into the word on the next edge, except that the reserved bits 11:8 stay 0.
- R7: When load_en_i and a non-zero alu_op_i arrive together, the load value is stored and the ALU update is discarded.
- R8: An ALU update leaves the processor-state and address-state fields unchanged. addr_state_o and proc_state_o always equal bits 3:0 and 7:4 of the word.
- R9: priv_viol_o is high in exactly those cycles where priv_insn_i is high and the stored processor-state field is non-zero. It is combinational from priv_insn_i.
- R10: cond_true_o is high when any condition bit selected by cond_mask_i is set (mask bit 3 = C, 2 = P, 1 = Z, 0 = N). An all-zero mask gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alu_result_i | input | DATA_W | ALU result used to derive P, Z, N |
| alu_carry_i | input | 1 | ALU carry out |
| alu_op_i | input | 2 | Operation class of the current ALU operation |
| load_en_i | input | 1 | Full-word load strobe |
| load_data_i | input | 16 | Value for a full-word load |
| priv_insn_i | input | 1 | A privileged instruction is executing |
| cond_mask_i | input | 4 | Selects the condition bits to test |
| status_o | output | 16 | Stored status word |
| addr_state_o | output | 4 | Address-state field to paging logic |
| proc_state_o | output | 4 | Processor-state field to protect logic |
| priv_viol_o | output | 1 | Illegal privileged instruction flag |
| cond_true_o | output | 1 | Any selected condition bit is set |

## Verification
The ALU path is driven with zero results, with results whose top bit is set, and with small positive results, under all three operation classes. This shows that the sign decode and the carry capture do not depend on the class, and that an idle class holds the word. Loads are issued alone, together with an ALU update, and with ones in the reserved bits, which separates load priority from the masking of the reserved bits. The privilege strobe is pulsed with the processor-state field at zero and at non-zero values. Random mixes of all inputs are then checked every clock against a behavioural model.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned C_BIT   = 15;
  localparam int unsigned P_BIT   = 14;
  localparam int unsigned Z_BIT   = 13;
  localparam int unsigned N_BIT   = 12;
  localparam int unsigned PS_LSB  = 4;
  localparam int unsigned AS_LSB  = 0;
  localparam logic [WORD_W-1:0] WRITE_MASK = 16'hF0FF;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOGIC = 2'd1,
    OP_SHIFT = 2'd2,
    OP_ARITH = 2'd3
  } op_class_e;

  typedef struct packed {
    logic c;
    logic p;
    logic z;
    logic n;
  } cond_t;
endpackage

// File: rtl/psr_flags.sv
module psr_flags
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  output cond_t             cond_o
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (result_i == '0);
  assign is_neg  = result_i[DATA_W-1];

  always_comb begin
    cond_o.c = carry_i;
    cond_o.z = is_zero;
    cond_o.n = is_neg;
    cond_o.p = !is_zero && !is_neg;
  end
endmodule

// File: rtl/psr_cond_test.sv
module psr_cond_test
  import psr_pkg::*;
(
  input  cond_t       cond_i,
  input  logic [3:0]  mask_i,
  output logic        hit_o
);
  assign hit_o = |(mask_i & {cond_i.c, cond_i.p, cond_i.z, cond_i.n});
endmodule

// File: rtl/psr_priv_chk.sv
module psr_priv_chk
  import psr_pkg::*;
(
  input  logic [FIELD_W-1:0] proc_state_i,
  input  logic               priv_insn_i,
  output logic               viol_o
);
  // zero key is the only privileged state
  assign viol_o = priv_insn_i && (proc_state_i != '0);
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] alu_result_i,
  input  logic              alu_carry_i,
  input  logic [1:0]        alu_op_i,
  input  logic              load_en_i,
  input  logic [15:0]       load_data_i,
  input  logic              priv_insn_i,
  input  logic [3:0]        cond_mask_i,
  output logic [15:0]       status_o,
  output logic [3:0]        addr_state_o,
  output logic [3:0]        proc_state_o,
  output logic              priv_viol_o,
  output logic              cond_true_o
);
  cond_t              cond_q, cond_new;
  logic [FIELD_W-1:0] ps_q, as_q;
  op_class_e          op_cls;
  logic               alu_upd;

  assign op_cls  = op_class_e'(alu_op_i);
  assign alu_upd = (op_cls != OP_NONE);

  psr_flags #(.DATA_W(DATA_W)) u_flags (
    .result_i (alu_result_i),
    .carry_i  (alu_carry_i),
    .cond_o   (cond_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      ps_q   <= '0;
      as_q   <= '0;
    end else if (load_en_i) begin
      cond_q <= cond_t'(load_data_i[C_BIT:N_BIT]);
      ps_q   <= load_data_i[PS_LSB +: FIELD_W];
      as_q   <= load_data_i[AS_LSB +: FIELD_W];
    end else if (alu_upd) begin
      cond_q <= cond_new;
    end
  end

  assign status_o     = {cond_q, 4'b0000, ps_q, as_q};
  assign addr_state_o = as_q;
  assign proc_state_o = ps_q;

  psr_priv_chk u_priv (
    .proc_state_i (ps_q),
    .priv_insn_i  (priv_insn_i),
    .viol_o       (priv_viol_o)
  );

  psr_cond_test u_test (
    .cond_i (cond_q),
    .mask_i (cond_mask_i),
    .hit_o  (cond_true_o)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[11:8] == 4'b0000);  // R2
  AST_CARRY_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i != 2'd0 && !load_en_i) |=> status_o[15] == $past(alu_carry_i));  // R3
  AST_ONE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i != 2'd0 && !load_en_i) |=> $countones(status_o[14:12]) == 1);  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i == 2'd0 && !load_en_i) |=> $stable(status_o));  // R5
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> status_o == ($past(load_data_i) & WRITE_MASK));  // R7
  AST_FIELDS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> status_o[7:0] == $past(status_o[7:0]));  // R8
  AST_PRIV_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_viol_o == (priv_insn_i && status_o[7:4] != 4'd0));  // R9
endmodule

// File: tb/sim_psr_core.sv
module sim_psr_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] alu_result_i = '0;
  logic        alu_carry_i = 1'b0;
  logic [1:0]  alu_op_i = '0;
  logic        load_en_i = 1'b0;
  logic [15:0] load_data_i = '0;
  logic        priv_insn_i = 1'b0;
  logic [3:0]  cond_mask_i = '0;
  logic [15:0] status_o;
  logic [3:0]  addr_state_o, proc_state_o;
  logic        priv_viol_o, cond_true_o;

  int checks = 0;
  int fails  = 0;
  int model  = 0;

  always #2.5 clk_i = ~clk_i;

  psr_core u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int next_model(int cur);
    int r;
    if (load_en_i) return int'(load_data_i) & 'hF0FF;
    if (alu_op_i == 0) return cur;
    r = cur & 'h00FF;
    if (alu_carry_i) r |= 'h8000;
    if (alu_result_i == 0) r |= 'h2000;
    else if (alu_result_i[15]) r |= 'h1000;
    else r |= 'h4000;
    return r;
  endfunction

  // drive, check comb outputs, clock, check stored word
  task automatic step(string req, logic [1:0] op, logic [15:0] res, logic cy,
                      logic ld, logic [15:0] ldd, logic pi, logic [3:0] msk);
    int c4;
    @(negedge clk_i);
    alu_op_i = op; alu_result_i = res; alu_carry_i = cy;
    load_en_i = ld; load_data_i = ldd; priv_insn_i = pi; cond_mask_i = msk;
    #1;
    c4 = (model >> 12) & 'hF;
    chk("R9 priv_viol", int'(priv_viol_o), (pi && ((model >> 4) & 'hF) != 0) ? 1 : 0);
    chk("R10 cond_true", int'(cond_true_o), ((c4 & int'(msk)) != 0) ? 1 : 0);
    @(posedge clk_i);
    model = next_model(model);
    @(negedge clk_i);
    chk(req, int'(status_o), model);
    chk("R8 as/ps mirror", int'({proc_state_o, addr_state_o}), model & 'hFF);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset word", int'(status_o), 0);
    chk("R1 reset viol", int'(priv_viol_o), 0);
    rst_ni = 1'b1;
    // R4 sign decode under each class, R3 carry
    step("R4 zero logic",   2'd1, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b0, 4'h2);
    step("R4 neg shift",    2'd2, 16'h8001, 1'b1, 1'b0, 16'h0, 1'b0, 4'h1);
    step("R4 pos arith",    2'd3, 16'h0005, 1'b0, 1'b0, 16'h0, 1'b0, 4'h4);
    step("R3 carry arith",  2'd3, 16'h7FFF, 1'b1, 1'b0, 16'h0, 1'b0, 4'h8);
    step("R5 idle hold",    2'd0, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b1, 4'hF);
    // R6 load with reserved ones, R2 layout
    step("R6 load mask",    2'd0, 16'h0000, 1'b0, 1'b1, 16'hAF35, 1'b0, 4'h0);
    chk("R2 ps field", int'(proc_state_o), 3);
    chk("R2 as field", int'(addr_state_o), 5);
    step("R9 viol nonzero", 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b1, 4'h8);
    step("R8 alu keeps fields", 2'd1, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b0, 4'h0);
    step("R7 load beats alu", 2'd3, 16'h8000, 1'b1, 1'b1, 16'h4000, 1'b1, 4'h4);
    step("R9 viol zero key", 2'd0, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b1, 4'h0);
    step("R10 mask zero",   2'd0, 16'h0000, 1'b0, 1'b0, 16'h0, 1'b0, 4'h0);
    for (int i = 0; i < 2000; i++) begin
      step("R3 R4 R5 R6 R7 random",
           2'($urandom), 16'(($urandom % 4 == 0) ? 0 : $urandom), 1'($urandom),
           ($urandom % 6 == 0), 16'($urandom), 1'($urandom), 4'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule